// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric of a chip. Each channel reports fire and clear events. The block turns each event into one of three deliveries, chosen by that channel's settings:

- a one-cycle pulse on an interrupt line;
- a line held high until software clears it;
- a memory-write request sent out as a message.

The block keeps one status bit per channel and drives a bank of interrupt lines. Software clears status bits with a write-one-to-clear status write. Bus decode and register storage are outside the block. Channel settings arrive as plain input vectors.

A legacy takeover mode pins channel 0 to a fixed first line and channel 1 to a fixed second line, ignoring their route fields. In this mode the block also masks an external real-time-clock interrupt level that normally passes through to that second line. The block always keeps the latest real-time-clock level, so leaving legacy mode puts the line straight back to the current level. Several sources may share a line; the line is the OR of all of them.

Message requests leave on a valid/ready stream. Once valid is high it stays high, and address and data stay unchanged, until a cycle in which ready is high. Each message-mode channel has one pending flag, which gives back-pressure coalescing: while the stream is stalled, repeated fires of one channel merge into a single request. When several channels are pending, the lowest-numbered channel is sent first. A message is captured from the channel's 64-bit route input when it is sent: the upper 32 bits become the address and the lower 32 bits the data.

Top module: `tirq_router`

## Requirements
- R1: With legacy mode on, a held or pulsed drive from channel 0 appears on line 0 and one from channel 1 appears on line 8, whatever their route fields. All other channels, and every channel when legacy mode is off, use their 5-bit route field as the line index.
- R2: A fire or clear event on a channel whose own enable is 0, or while the global enable is 0, clears that channel's status bit. It also drops that channel's held line, unless the channel is in message mode. A clear event on an enabled channel has the same effect.
- R3: A fire on an enabled level-type channel (level bit 1) sets its status bit and holds its line high from the cycle after the fire until the channel is cleared.
- R4: A fire on an enabled edge-type channel (level bit 0) leaves its status bit at 0 and drives its line high for exactly the one cycle after the fire.
- R5: A fire on an enabled channel in message mode drives no line, leaves its status bit unchanged, and queues a request. The request's address is bits 63:32 of that channel's route input and its data is bits 31:0.
- R6: A request appears on the stream two cycles after the fire. While valid is high and ready is low, valid, address and data hold. Pending channels are sent lowest index first, and each pending fire produces exactly one request.
- R7: A status write clears each status bit that is 1 in both the written value and the current status, and drops that channel's held line. Written 0 bits, and 1 bits whose status is already 0, change nothing.
- R8: When a channel's message-mode bit changes from 0 to 1, that channel's status bit is cleared and its held line is dropped.
- R9: The real-time-clock input is registered once. It drives line 8 only while legacy mode is off. While legacy mode is on, line 8 ignores it, but its latest value is kept, so leaving legacy mode puts line 8 at the current level one cycle later.
- R10: A line whose sources are several channels and/or the real-time-clock input is high whenever any one of those sources is active.
- R11: After reset all lines are low, all status bits are 0 and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | NUM_CH | Per-channel fire event |
| clear_i | input | NUM_CH | Per-channel clear event |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_level_i | input | NUM_CH | 1 = level-held delivery, 0 = edge pulse |
| ch_msg_en_i | input | NUM_CH | Per-channel message delivery select |
| ch_route_i | input | NUM_CH*5 | Line index per channel, channel c at bits [5c+4:5c] |
| ch_msg_route_i | input | NUM_CH*64 | Message address (upper 32) and data (lower 32) per channel |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy takeover mode |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NUM_CH | Status write-one-to-clear value |
| rtc_level_i | input | 1 | External real-time-clock interrupt level |
| irq_lines_o | output | 32 | Interrupt lines |
| status_o | output | NUM_CH | Per-channel status bits |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message sink ready |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The hardest case to reach is the one where the real-time-clock level changes while legacy mode masks it, so that the stored value differs from what line 8 shows. The bench toggles the clock input low and then high, and separately high and then low, inside a legacy window. It then leaves legacy mode and checks that line 8 follows only the last value. Stalled message traffic is reached by holding ready low while two message-mode channels fire in the same cycle. The bench then checks the held request and the lowest-index-first order through a scoreboard queue.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_DROP,
    ACT_HOLD,
    ACT_PULSE,
    ACT_MSG
  } tirq_act_e;

endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
  import tirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clear_i,
  input  logic en_i,
  input  logic level_i,
  input  logic msg_en_i,
  input  logic glb_en_i,
  input  logic sts_clr_i,
  output logic status_o,
  output logic drive_o,
  output logic msg_req_o
);

  tirq_act_e act;
  logic msg_en_q, hold_q, pulse_q, status_q;
  logic hold_n, pulse_n, status_n;
  logic msg_rise;

  always_comb begin
    act = ACT_NONE;
    if (fire_i || clear_i) begin
      if (!fire_i || !en_i || !glb_en_i) act = ACT_DROP;
      else if (msg_en_i)                  act = ACT_MSG;
      else if (level_i)                   act = ACT_HOLD;
      else                                act = ACT_PULSE;
    end
  end

  assign msg_rise = msg_en_i & ~msg_en_q;

  always_comb begin
    status_n = status_q;
    hold_n   = hold_q;
    pulse_n  = 1'b0;
    if (sts_clr_i || msg_rise) begin
      status_n = 1'b0;
      hold_n   = 1'b0;
    end
    case (act)
      ACT_DROP: begin
        status_n = 1'b0;
        if (!msg_en_i) hold_n = 1'b0;
      end
      ACT_HOLD: begin
        status_n = 1'b1;
        hold_n   = 1'b1;
      end
      ACT_PULSE: begin
        status_n = 1'b0;
        hold_n   = 1'b0;
        pulse_n  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_en_q <= 1'b0;
      hold_q   <= 1'b0;
      pulse_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      msg_en_q <= msg_en_i;
      hold_q   <= hold_n;
      pulse_q  <= pulse_n;
      status_q <= status_n;
    end
  end

  assign status_o  = status_q;
  assign drive_o   = hold_q | pulse_q;
  assign msg_req_o = (act == ACT_MSG);

  // R7: a held line always has its status bit set
  p_hold_has_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> status_q);

  // R4: an edge pulse lasts one cycle unless a new fire arrived
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> (!pulse_q || $past(fire_i)));

  // R5: message-mode channels never start holding a line
  p_msg_no_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !$past(msg_en_i));

endmodule

// File: rtl/tirq_line_map.sv
module tirq_line_map #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 32,
  parameter int LEG_A     = 0,
  parameter int LEG_B     = 8,
  localparam int RW       = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      drive_i,
  input  logic [NUM_CH*RW-1:0]   route_i,
  input  logic                   legacy_i,
  input  logic                   rtc_i,
  output logic [NUM_LINES-1:0]   lines_o
);

  localparam logic [RW-1:0] LA = RW'(LEG_A);
  localparam logic [RW-1:0] LB = RW'(LEG_B);

  logic legacy_q, rtc_q;
  logic [RW-1:0] eff [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      rtc_q    <= 1'b0;
    end else begin
      legacy_q <= legacy_i;
      rtc_q    <= rtc_i;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      eff[c] = route_i[c*RW +: RW];
      if (legacy_q && c == 0) eff[c] = LA;
      if (legacy_q && c == 1) eff[c] = LB;
    end
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [NUM_CH-1:0] hit;
    always_comb begin
      for (int c = 0; c < NUM_CH; c++) hit[c] = drive_i[c] && (eff[c] == RW'(k));
    end
    if (k == LEG_B) begin : g_rtc
      assign lines_o[k] = (|hit) | (rtc_q & ~legacy_q);
    end else begin : g_plain
      assign lines_o[k] = |hit;
    end
  end

  // R9: an unmasked clock level reaches its line
  p_rtc_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_q && rtc_q) |-> lines_o[LEG_B]);

  // R1: legacy mode pins channel 0 to its fixed line
  p_legacy_ch0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_q && drive_i[0]) |-> lines_o[LEG_A]);

endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int MW    = AW + DW,
  localparam int SW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     req_i,
  input  logic [NUM_CH*MW-1:0]  route_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic [AW-1:0]         addr_o,
  output logic [DW-1:0]         data_o
);

  logic [NUM_CH-1:0] pending_q, grant_oh;
  logic [SW-1:0]     sel;
  logic              any, load;
  logic              valid_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;

  always_comb begin
    sel = '0;
    any = |pending_q;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pending_q[c]) sel = SW'(c);
    end
  end

  assign load     = (!valid_q || ready_i) && any;
  assign grant_oh = load ? (NUM_CH'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      valid_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      pending_q <= (pending_q & ~grant_oh) | req_i;
      if (load) begin
        valid_q <= 1'b1;
        addr_q  <= route_i[sel*MW + DW +: AW];
        data_q  <= route_i[sel*MW +: DW];
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R6: a stalled request keeps its payload
  p_msg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));

endmodule

// File: rtl/tirq_router.sv
module tirq_router #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 32,
  parameter int MSG_AW    = 32,
  parameter int MSG_DW    = 32,
  parameter int LEG_A     = 0,
  parameter int LEG_B     = 8,
  localparam int RW       = $clog2(NUM_LINES),
  localparam int MW       = MSG_AW + MSG_DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     fire_i,
  input  logic [NUM_CH-1:0]     clear_i,
  input  logic [NUM_CH-1:0]     ch_en_i,
  input  logic [NUM_CH-1:0]     ch_level_i,
  input  logic [NUM_CH-1:0]     ch_msg_en_i,
  input  logic [NUM_CH*RW-1:0]  ch_route_i,
  input  logic [NUM_CH*MW-1:0]  ch_msg_route_i,
  input  logic                  glb_en_i,
  input  logic                  legacy_i,
  input  logic                  sts_wr_i,
  input  logic [NUM_CH-1:0]     sts_wdata_i,
  input  logic                  rtc_level_i,
  output logic [NUM_LINES-1:0]  irq_lines_o,
  output logic [NUM_CH-1:0]     status_o,
  output logic                  msg_valid_o,
  input  logic                  msg_ready_i,
  output logic [MSG_AW-1:0]     msg_addr_o,
  output logic [MSG_DW-1:0]     msg_data_o
);

  logic [NUM_CH-1:0] status, drive, msg_req, sts_clr;

  assign sts_clr = sts_wr_i ? (sts_wdata_i & status) : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tirq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire_i[c]),
      .clear_i   (clear_i[c]),
      .en_i      (ch_en_i[c]),
      .level_i   (ch_level_i[c]),
      .msg_en_i  (ch_msg_en_i[c]),
      .glb_en_i  (glb_en_i),
      .sts_clr_i (sts_clr[c]),
      .status_o  (status[c]),
      .drive_o   (drive[c]),
      .msg_req_o (msg_req[c])
    );
  end

  tirq_line_map #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .LEG_A     (LEG_A),
    .LEG_B     (LEG_B)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_i  (drive),
    .route_i  (ch_route_i),
    .legacy_i (legacy_i),
    .rtc_i    (rtc_level_i),
    .lines_o  (irq_lines_o)
  );

  tirq_msg_arb #(
    .NUM_CH (NUM_CH),
    .AW     (MSG_AW),
    .DW     (MSG_DW)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (msg_req),
    .route_i (ch_msg_route_i),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .addr_o  (msg_addr_o),
    .data_o  (msg_data_o)
  );

  assign status_o = status;

  // R7: a status write never sets a bit
  p_sts_write_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_i && !(|fire_i)) |=> ((status_o & ~$past(status_o)) == '0));

endmodule

// File: tb/tirq_router_bench.sv
module tirq_router_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] fire_v = '0, clear_v = '0, en_v = '1, level_v = '0, msg_en_v = '0;
  logic [N*5-1:0] route_v = '0;
  logic [N*64-1:0] mroute_v = '0;
  logic glb_en = 1'b1, legacy = 1'b0, sts_wr = 1'b0, rtc = 1'b0, ready = 1'b1;
  logic [N-1:0] sts_wd = '0;
  logic [31:0] lines;
  logic [N-1:0] status;
  logic valid;
  logic [31:0] maddr, mdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  tirq_router u_tirq_router (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_v), .clear_i(clear_v),
    .ch_en_i(en_v), .ch_level_i(level_v), .ch_msg_en_i(msg_en_v),
    .ch_route_i(route_v), .ch_msg_route_i(mroute_v), .glb_en_i(glb_en),
    .legacy_i(legacy), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wd),
    .rtc_level_i(rtc), .irq_lines_o(lines), .status_o(status),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_addr_o(maddr),
    .msg_data_o(mdata)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic fire(int c);
    fire_v[c] = 1'b1; tick(); fire_v[c] = 1'b0;
  endtask

  task automatic clr(int c);
    clear_v[c] = 1'b1; tick(); clear_v[c] = 1'b0;
  endtask

  task automatic swrite(logic [N-1:0] w);
    sts_wr = 1'b1; sts_wd = w; tick(); sts_wr = 1'b0; sts_wd = '0;
  endtask

  // scoreboard monitor: compare each accepted request
  always begin
    @(negedge clk); #1;
    if (rst_n && valid && ready) begin
      if (exp_q.size() == 0) chk("R6 unexpected request", {maddr, mdata}, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R5 request payload", {maddr, mdata}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R11 lines", lines, 0);
    chk("R11 status", status, 0);
    chk("R11 valid", valid, 0);

    // R3 level hold
    level_v[0] = 1; route_v[0*5 +: 5] = 5;
    fire(0);
    chk("R3 line", lines, 32'h1 << 5);
    chk("R3 status", status, 4'b0001);
    tick();
    chk("R3 held", lines, 32'h1 << 5);

    // R7 status write
    level_v[2] = 1; route_v[2*5 +: 5] = 7;
    fire(2);
    chk("R7 setup", lines, (32'h1 << 5) | (32'h1 << 7));
    swrite(4'b0010);
    chk("R7 zero-status bit", status, 4'b0101);
    chk("R7 lines kept", lines, (32'h1 << 5) | (32'h1 << 7));
    swrite(4'b0001);
    chk("R7 cleared status", status, 4'b0100);
    chk("R7 cleared line", lines, 32'h1 << 7);

    // R4 edge pulse
    route_v[1*5 +: 5] = 3;
    fire(1);
    chk("R4 pulse", lines, (32'h1 << 7) | (32'h1 << 3));
    chk("R4 status", status, 4'b0100);
    tick();
    chk("R4 pulse ends", lines, 32'h1 << 7);

    // R2 disabled channel and global enable
    en_v[2] = 0;
    clr(2);
    chk("R2 disabled line", lines, 0);
    chk("R2 disabled status", status, 0);
    en_v[2] = 1;
    fire(0);
    chk("R2 setup", lines, 32'h1 << 5);
    glb_en = 0;
    fire(0);
    chk("R2 global off line", lines, 0);
    chk("R2 global off status", status, 0);
    glb_en = 1;

    // R8 message enable rise clears
    level_v[3] = 1; route_v[3*5 +: 5] = 10;
    fire(3);
    chk("R8 setup", lines, 32'h1 << 10);
    msg_en_v[3] = 1;
    tick();
    chk("R8 line dropped", lines, 0);
    chk("R8 status cleared", status, 0);

    // R5 / R6 message delivery with back-pressure
    mroute_v[3*64 +: 64] = 64'hFEED0040_12345678;
    mroute_v[2*64 +: 64] = 64'h00000080_000000A5;
    msg_en_v[2] = 1;
    tick();
    ready = 0;
    exp_q.push_back(64'h00000080_000000A5);
    exp_q.push_back(64'hFEED0040_12345678);
    fire_v[2] = 1; fire_v[3] = 1; tick(); fire_v = '0;
    chk("R5 no line", lines, 0);
    chk("R5 status unchanged", status, 0);
    repeat (3) tick();
    chk("R6 held valid", valid, 1);
    chk("R6 lowest first", {maddr, mdata}, 64'h00000080_000000A5);
    ready = 1;
    for (int i = 0; i < 10 && exp_q.size() != 0; i++) tick();
    repeat (2) tick();
    chk("R6 all delivered", exp_q.size(), 0);
    chk("R6 idle", valid, 0);
    msg_en_v[2] = 0; msg_en_v[3] = 0;
    level_v[3] = 0;

    // R1 legacy routing
    legacy = 1; tick();
    route_v[0*5 +: 5] = 9; route_v[1*5 +: 5] = 4;
    fire(0);
    chk("R1 ch0 to line0", lines, 32'h1);
    fire(1);
    chk("R1 ch1 to line8", lines, 32'h1 | (32'h1 << 8));
    tick();
    chk("R1 pulse ends", lines, 32'h1);
    swrite(4'b0001);
    route_v[2*5 +: 5] = 9;
    fire(2);
    chk("R1 other channel uses route", lines, 32'h1 << 9);
    swrite(4'b0100);
    chk("R1 cleared", lines, 0);

    // R9 clock level forwarding and masking
    legacy = 0; rtc = 1; tick();
    chk("R9 forwarded", lines, 32'h1 << 8);
    legacy = 1; tick();
    chk("R9 masked", lines, 0);
    rtc = 0; tick(); rtc = 1; tick();
    chk("R9 still masked", lines, 0);
    legacy = 0; tick();
    chk("R9 restored high", lines, 32'h1 << 8);
    legacy = 1; tick(); rtc = 0; tick();
    legacy = 0; tick();
    chk("R9 restored low", lines, 0);

    // R10 shared lines
    rtc = 1; route_v[2*5 +: 5] = 8; tick();
    fire(2);
    rtc = 0; tick();
    chk("R10 channel keeps shared line", lines, 32'h1 << 8);
    swrite(4'b0100);
    chk("R10 released", lines, 0);
    route_v[0*5 +: 5] = 6; route_v[2*5 +: 5] = 6;
    fire(0); fire(2);
    swrite(4'b0001);
    chk("R10 other holder keeps line", lines, 32'h1 << 6);
    swrite(4'b0100);
    chk("R10 all released", lines, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule